// File: doc/BRIEF.md
# Safe system clock switch sequencer

This block changes the source and the divider of the system clock so that the clock never runs faster than intended while the change is in progress. A request consists of a new source code, a new divider field and a one-cycle start strobe. The sequencer first switches the internal RC oscillator on and waits for it to report stable. It then parks the system clock on that oscillator and loads the new divider while parked. Next it waits for the requested source to report stable, moves the clock onto that source, and finally switches the RC oscillator off again if it was not already stable when the request arrived.

The outputs have the form of register fields: an RC oscillator enable, a 3-bit source select and a 4-bit divider field, where the divide ratio is the field value plus one. The oscillators and the glitch-free clock multiplexers sit outside the block. Each oscillator returns one stable flag, indexed by its source code. The RC oscillator uses source code 7. Every wait for a stable flag has a cycle budget. When the budget runs out, the sequence stops with the clock on the last safe selection, and a sticky error flag is raised.

Top module: `sysclk_switch_seq`

## Requirements
- R1: After reset, the RC enable is 1, the source select is 7 (RC oscillator), the divider field is 0, and busy, done and error are all 0.
- R2: A start accepted while idle drives the RC enable to 1 at the accepting clock edge. Source select and divider stay unchanged until the RC stable flag has been seen.
- R3: The source select becomes 7 before the divider field changes. The divider field only ever changes while the source select is 7.
- R4: On completion, the divider field equals the requested 4-bit value, and the divide ratio is that value plus 1.
- R5: The requested source code is applied only after the divider has been written and the flag of that source has been seen stable. On completion, the source select equals the requested code.
- R6: On completion, the RC enable is 1 if the RC stable flag was high when the start was accepted, or if the requested source is 7. Otherwise it is 0. The enable never falls while the source select is 7.
- R7: Each wait lasts at most POLL_LIMIT cycles. A stable flag first seen in the last cycle of the budget still lets the sequence go on. With no flag, busy stays high for exactly POLL_LIMIT cycles in the RC wait.
- R8: On a timeout, the error flag goes to 1 and stays there until the next accepted start clears it, and done does not pulse. After an RC-wait timeout, source and divider are unchanged, and the RC enable returns to 0 under the R6 condition. After a target-wait timeout, the source select stays 7, the new divider is kept and the RC enable stays 1.
- R9: A start pulse while busy is ignored: it neither changes the request in progress nor starts another sequence.
- R10: Busy is high from the accepting edge to the end of the sequence. Done pulses for exactly one cycle, in the first idle cycle after a completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| new_src_i | input | SEL_W (3) | Requested clock source code |
| new_div_i | input | DIV_W (4) | Requested divider field (ratio = field + 1) |
| osc_stable_i | input | 2^SEL_W (8) | Stable flag of each source, indexed by source code |
| rc_en_o | output | 1 | RC oscillator enable |
| sys_src_o | output | SEL_W (3) | System clock source select |
| sys_div_o | output | DIV_W (4) | System clock divider field |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout flag |

## Verification
The bench sweeps every source code against every divider value and watches the outputs every cycle for three failure modes. A divider write made before the park would show up as the divider moving while the source is not 7. A source switch made too early would show up before the divider takes its new value. An RC enable dropped too early would fall while the clock still sits on the RC oscillator. It drives the RC wait to both edges of the poll budget. A stable flag in the last cycle must complete the sequence, while a flag one cycle later must time out in exactly POLL_LIMIT busy cycles, so an off-by-one in the budget fails one of the two cases. It also covers the restore rule in both of its branches: one request starts with the RC oscillator off and targets it, the other starts with it off and targets another source. A design that only looked at the original enable state would switch off the clock it had just selected. Finally it pulses start in the middle of a sequence. A design that re-latched the request would end on the wrong source or pulse done twice.

// File: rtl/sysclk_switch_pkg.sv
package sysclk_switch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_RC  = 3'd1,
    ST_PARK     = 3'd2,
    ST_LOAD_DIV = 3'd3,
    ST_WAIT_TGT = 3'd4,
    ST_SWITCH   = 3'd5,
    ST_FINISH   = 3'd6
  } seq_state_e;

  // Next step of the switch sequence. A stable flag takes priority over
  // budget expiry in the same cycle.
  function automatic seq_state_e seq_next(input seq_state_e cur,
                                          input logic accept,
                                          input logic rc_ready,
                                          input logic tgt_ready,
                                          input logic expired);
    seq_state_e nxt;
    nxt = cur;
    unique case (cur)
      ST_IDLE:     if (accept) nxt = ST_WAIT_RC;
      ST_WAIT_RC:  begin
        if (rc_ready)     nxt = ST_PARK;
        else if (expired) nxt = ST_IDLE;
      end
      ST_PARK:     nxt = ST_LOAD_DIV;
      ST_LOAD_DIV: nxt = ST_WAIT_TGT;
      ST_WAIT_TGT: begin
        if (tgt_ready)    nxt = ST_SWITCH;
        else if (expired) nxt = ST_IDLE;
      end
      ST_SWITCH:   nxt = ST_FINISH;
      ST_FINISH:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // The RC oscillator may be switched off only if it was not already
  // stable when the request came in and the clock is not running from it.
  function automatic logic drop_rc(input logic was_stable, input logic on_rc);
    return !was_stable && !on_rc;
  endfunction

  // Divide ratio encoded by a divider field value.
  function automatic int unsigned div_ratio(input int unsigned field);
    return field + 1;
  endfunction

endpackage

// File: rtl/sysclk_switch_poll_timer.sv
module sysclk_switch_poll_timer #(
  parameter int unsigned POLL_LIMIT = 1200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);

  localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = run_i && (cnt_q == LAST);

  // R7: every wait starts from an empty budget
  a_r7_fresh_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_q == '0));

  // R7: the count never passes the last budget cycle
  a_r7_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
  import sysclk_switch_pkg::*;
#(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DIV_W = 4,
  parameter logic [SEL_W-1:0] RC_SRC = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [SEL_W-1:0]      new_src_i,
  input  logic [DIV_W-1:0]      new_div_i,
  input  logic [(2**SEL_W)-1:0] osc_stable_i,
  input  logic [SEL_W-1:0]      cur_src_i,
  input  logic                  expired_i,
  output logic                  busy_o,
  output logic                  run_timer_o,
  output logic                  cmd_rc_on_o,
  output logic                  cmd_park_o,
  output logic                  cmd_div_o,
  output logic                  cmd_switch_o,
  output logic                  cmd_rc_off_o,
  output logic                  done_set_o,
  output logic                  err_set_o,
  output logic                  err_clr_o,
  output logic [SEL_W-1:0]      req_src_o,
  output logic [DIV_W-1:0]      req_div_o
);

  seq_state_e       state_q, state_d;
  logic [SEL_W-1:0] req_src_q;
  logic [DIV_W-1:0] req_div_q;
  logic             rc_was_q;

  // Named internal events
  logic ev_accept;
  logic ev_rc_ready;
  logic ev_tgt_ready;
  logic ev_timeout;
  logic ev_abort_rc;

  assign ev_accept    = (state_q == ST_IDLE) && start_i;
  assign ev_rc_ready  = osc_stable_i[RC_SRC];
  assign ev_tgt_ready = osc_stable_i[req_src_q];
  assign ev_abort_rc  = (state_q == ST_WAIT_RC) && !ev_rc_ready && expired_i;
  assign ev_timeout   = ev_abort_rc ||
                        ((state_q == ST_WAIT_TGT) && !ev_tgt_ready && expired_i);

  assign state_d = seq_next(state_q, ev_accept, ev_rc_ready, ev_tgt_ready, expired_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_src_q <= RC_SRC;
      req_div_q <= '0;
      rc_was_q  <= 1'b1;
    end else if (ev_accept) begin
      req_src_q <= new_src_i;
      req_div_q <= new_div_i;
      rc_was_q  <= osc_stable_i[RC_SRC];
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign run_timer_o  = (state_q == ST_WAIT_RC) || (state_q == ST_WAIT_TGT);
  assign cmd_rc_on_o  = ev_accept;
  assign cmd_park_o   = (state_q == ST_PARK);
  assign cmd_div_o    = (state_q == ST_LOAD_DIV);
  assign cmd_switch_o = (state_q == ST_SWITCH);
  assign cmd_rc_off_o = ((state_q == ST_FINISH) || ev_abort_rc) &&
                        drop_rc(rc_was_q, cur_src_i == RC_SRC);
  assign done_set_o   = (state_q == ST_FINISH);
  assign err_set_o    = ev_timeout;
  assign err_clr_o    = ev_accept;
  assign req_src_o    = req_src_q;
  assign req_div_o    = req_div_q;

  // R9: a start seen while busy leaves the latched request untouched
  a_r9_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(req_src_q) && $stable(req_div_q)));

  // R5: the switch step is reached only through a seen target flag
  a_r5_switch_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWITCH) |-> $past(ev_tgt_ready));

endmodule

// File: rtl/sysclk_switch_outregs.sv
module sysclk_switch_outregs #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DIV_W = 4,
  parameter logic [SEL_W-1:0] RC_SRC = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_rc_on_i,
  input  logic             cmd_park_i,
  input  logic             cmd_div_i,
  input  logic             cmd_switch_i,
  input  logic             cmd_rc_off_i,
  input  logic             done_set_i,
  input  logic             err_set_i,
  input  logic             err_clr_i,
  input  logic [SEL_W-1:0] req_src_i,
  input  logic [DIV_W-1:0] req_div_i,
  output logic             rc_en_o,
  output logic [SEL_W-1:0] src_o,
  output logic [DIV_W-1:0] div_o,
  output logic             done_o,
  output logic             err_o
);

  logic             rc_en_q;
  logic [SEL_W-1:0] src_q;
  logic [DIV_W-1:0] div_q;
  logic             done_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_en_q <= 1'b1;
    end else if (cmd_rc_on_i) begin
      rc_en_q <= 1'b1;
    end else if (cmd_rc_off_i) begin
      rc_en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= RC_SRC;
    end else if (cmd_park_i) begin
      src_q <= RC_SRC;
    end else if (cmd_switch_i) begin
      src_q <= req_src_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (cmd_div_i) begin
      div_q <= req_div_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_set_i;
      if (err_clr_i) begin
        err_q <= 1'b0;
      end else if (err_set_i) begin
        err_q <= 1'b1;
      end
    end
  end

  assign rc_en_o = rc_en_q;
  assign src_o   = src_q;
  assign div_o   = div_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R3: a divider change is only ever seen with the clock parked on RC
  a_r3_div_while_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> (src_q == RC_SRC));

  // R6: the RC enable never drops while the clock runs from it
  a_r6_rc_drop_off_rc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rc_en_q) |-> (src_q != RC_SRC));

  // R5: source moves happen only with the RC oscillator enabled
  a_r5_src_moves_rc_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_q) |-> rc_en_q);

  // R10: done lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R8: a timed-out sequence never reports done
  a_r8_err_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !done_q);

endmodule

// File: rtl/sysclk_switch_seq.sv
module sysclk_switch_seq #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned DIV_W = 4,
  parameter logic [SEL_W-1:0] RC_SRC = '1,
  parameter int unsigned POLL_LIMIT = 1200000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [SEL_W-1:0]      new_src_i,
  input  logic [DIV_W-1:0]      new_div_i,
  input  logic [(2**SEL_W)-1:0] osc_stable_i,
  output logic                  rc_en_o,
  output logic [SEL_W-1:0]      sys_src_o,
  output logic [DIV_W-1:0]      sys_div_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o
);

  logic             run_timer;
  logic             expired;
  logic             cmd_rc_on;
  logic             cmd_park;
  logic             cmd_div;
  logic             cmd_switch;
  logic             cmd_rc_off;
  logic             done_set;
  logic             err_set;
  logic             err_clr;
  logic [SEL_W-1:0] req_src;
  logic [DIV_W-1:0] req_div;

  sysclk_switch_poll_timer #(
    .POLL_LIMIT (POLL_LIMIT)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_timer),
    .expired_o (expired)
  );

  sysclk_switch_ctrl #(
    .SEL_W  (SEL_W),
    .DIV_W  (DIV_W),
    .RC_SRC (RC_SRC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .new_src_i    (new_src_i),
    .new_div_i    (new_div_i),
    .osc_stable_i (osc_stable_i),
    .cur_src_i    (sys_src_o),
    .expired_i    (expired),
    .busy_o       (busy_o),
    .run_timer_o  (run_timer),
    .cmd_rc_on_o  (cmd_rc_on),
    .cmd_park_o   (cmd_park),
    .cmd_div_o    (cmd_div),
    .cmd_switch_o (cmd_switch),
    .cmd_rc_off_o (cmd_rc_off),
    .done_set_o   (done_set),
    .err_set_o    (err_set),
    .err_clr_o    (err_clr),
    .req_src_o    (req_src),
    .req_div_o    (req_div)
  );

  sysclk_switch_outregs #(
    .SEL_W  (SEL_W),
    .DIV_W  (DIV_W),
    .RC_SRC (RC_SRC)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_rc_on_i  (cmd_rc_on),
    .cmd_park_i   (cmd_park),
    .cmd_div_i    (cmd_div),
    .cmd_switch_i (cmd_switch),
    .cmd_rc_off_i (cmd_rc_off),
    .done_set_i   (done_set),
    .err_set_i    (err_set),
    .err_clr_i    (err_clr),
    .req_src_i    (req_src),
    .req_div_i    (req_div),
    .rc_en_o      (rc_en_o),
    .src_o        (sys_src_o),
    .div_o        (sys_div_o),
    .done_o       (done_o),
    .err_o        (err_o)
  );

  // R2: a sequence always begins with the RC oscillator enabled
  a_r2_busy_with_rc_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> rc_en_o);

  // R10: done follows the end of busy
  a_r10_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($fell(busy_o) && !busy_o));

endmodule

// File: tb/sysclk_switch_seq_tb.sv
`timescale 1ns/1ps
module sysclk_switch_seq_tb;

  localparam int LIMIT = 16;
  localparam int RC    = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] new_src = '0;
  logic [3:0] new_div = '0;
  logic [7:0] osc_stable;
  logic       rc_en, busy, done, err;
  logic [2:0] src;
  logic [3:0] dv;

  logic [7:0] osc_ok = 8'hFF;
  int         rc_cnt = 0;
  int         rc_dly = 10;
  logic       rc_stable;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  int cur_tgt = RC;
  int cur_div = 0;
  int seq_busy, seq_done;
  bit seq_rc0;
  int first_rc, first_src, first_div, first_err;

  always #2 clk = ~clk;

  sysclk_switch_seq #(
    .POLL_LIMIT (LIMIT)
  ) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .new_src_i    (new_src),
    .new_div_i    (new_div),
    .osc_stable_i (osc_stable),
    .rc_en_o      (rc_en),
    .sys_src_o    (src),
    .sys_div_o    (dv),
    .busy_o       (busy),
    .done_o       (done),
    .err_o        (err)
  );

  // RC oscillator model: stable once enabled for rc_dly cycles
  always @(posedge clk) begin
    if (!rst_n || !rc_en) rc_cnt <= 0;
    else if (rc_cnt < 100000) rc_cnt <= rc_cnt + 1;
  end
  assign rc_stable  = rc_en && (rc_cnt >= rc_dly);
  assign osc_stable = {rc_stable, osc_ok[6:0]};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog R10: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // Ordering monitor over the outputs
  logic [2:0] prev_src;
  logic [3:0] prev_div;
  logic       prev_rc;
  bit         mon_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mon_valid) begin
        if (dv !== prev_div) chk("R3 divider changed off the RC source", int'(prev_src), RC);
        if (src !== prev_src && src !== 3'(RC)) begin
          chk("R5 divider written before switch", int'(dv), cur_div);
          chk("R5 switched to requested source", int'(src), cur_tgt);
        end
        if (prev_rc && !rc_en) chk("R6 RC enable fell while on RC", (src == 3'(RC)) ? 1 : 0, 0);
      end
      prev_src  = src;
      prev_div  = dv;
      prev_rc   = rc_en;
      mon_valid = 1'b1;
    end
  end

  // Starts a request at the current negedge and follows it until idle.
  task automatic run_seq(input int tgt, input int dvv, input bit inject);
    int idle_seen;
    seq_rc0 = rc_stable;
    start   = 1'b1;
    new_src = 3'(tgt);
    new_div = 4'(dvv);
    cur_tgt = tgt;
    cur_div = dvv;
    @(negedge clk);
    start     = 1'b0;
    seq_busy  = 0;
    seq_done  = 0;
    idle_seen = 0;
    first_rc  = int'(rc_en);
    first_src = int'(src);
    first_div = int'(dv);
    first_err = int'(err);
    for (int i = 0; i < LIMIT * 4 + 40 && idle_seen < 3; i++) begin
      if (busy) seq_busy++;
      else idle_seen++;
      if (done) seq_done++;
      if (inject && i == 2) begin
        start   = 1'b1;
        new_src = 3'd0;
        new_div = 4'd1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rc enable", int'(rc_en), 1);
    chk("R1 source", int'(src), RC);
    chk("R1 divider", int'(dv), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 error", int'(err), 0);

    // RC enabled but not yet settled: restore turns it off
    rc_dly = 10;
    run_seq(2, 3, 0);
    chk("R5 final source", int'(src), 2);
    chk("R4 final divider", int'(dv), 3);
    chk("R6 rc restored", int'(rc_en), (seq_rc0 || 2 == RC) ? 1 : 0);
    chk("R10 one done pulse", seq_done, 1);
    chk("R8 no error", int'(err), 0);

    // Stable flag in the last budget cycle still succeeds
    rc_dly = LIMIT - 1;
    run_seq(1, 6, 0);
    chk("R2 rc on at accept", first_rc, 1);
    chk("R2 source held", first_src, 2);
    chk("R2 divider held", first_div, 3);
    chk("R7 busy for last-cycle flag", seq_busy, LIMIT + 5);
    chk("R5 final source", int'(src), 1);
    chk("R4 final divider", int'(dv), 6);
    chk("R6 rc restored", int'(rc_en), 0);
    chk("R10 one done pulse", seq_done, 1);

    // One cycle later: RC wait times out
    rc_dly = LIMIT;
    run_seq(4, 9, 0);
    chk("R7 busy for RC timeout", seq_busy, LIMIT);
    chk("R8 error raised", int'(err), 1);
    chk("R8 no done on timeout", seq_done, 0);
    chk("R8 source kept", int'(src), 1);
    chk("R8 divider kept", int'(dv), 6);
    chk("R8 rc enable returned", int'(rc_en), 0);

    // RC off at start, target is RC: it must stay on; error clears
    rc_dly = 2;
    run_seq(RC, 2, 0);
    chk("R8 error cleared by start", first_err, 0);
    chk("R5 final source", int'(src), RC);
    chk("R4 final divider", int'(dv), 2);
    chk("R6 rc kept for RC target", int'(rc_en), 1);
    chk("R10 one done pulse", seq_done, 1);

    // Target never settles
    osc_ok[5] = 1'b0;
    run_seq(5, 11, 0);
    chk("R7 busy for target timeout", seq_busy, LIMIT + 3);
    chk("R8 error raised", int'(err), 1);
    chk("R8 no done on timeout", seq_done, 0);
    chk("R8 parked on RC", int'(src), RC);
    chk("R8 new divider kept", int'(dv), 11);
    chk("R8 rc kept on", int'(rc_en), 1);
    osc_ok[5] = 1'b1;

    // Start pulse while busy is ignored
    run_seq(3, 8, 1);
    chk("R9 source from first request", int'(src), 3);
    chk("R9 divider from first request", int'(dv), 8);
    chk("R9 single done", seq_done, 1);
    repeat (4) @(negedge clk);
    chk("R9 no second sequence", int'(busy), 0);
    chk("R9 source still held", int'(src), 3);

    // Sweep every source code against every divider field
    for (int t = 0; t < 8; t++) begin
      for (int d = 0; d < 16; d++) begin
        run_seq(t, d, 0);
        chk("R5 sweep source", int'(src), t);
        chk("R4 sweep divider", int'(dv), d);
        chk("R6 sweep rc enable", int'(rc_en), (seq_rc0 || t == RC) ? 1 : 0);
        chk("R10 sweep done", seq_done, 1);
        chk("R10 sweep busy length", seq_busy, seq_rc0 ? 6 : seq_busy);
        chk("R8 sweep no error", int'(err), 0);
      end
    end

    summary();
    $finish;
  end

endmodule